// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the hardwired control and datapath core of a small 8-bit accumulator processor. It walks each instruction through an opcode fetch, a decode step and an execute step. For two-byte instructions, an operand-address fetch is added. The block drives a single shared memory bus with an address, a read/write line, a request strobe and write data, and it takes read data back. It holds the program counter, the instruction register, an operand address register, the accumulator and a zero flag.

Slow memory or I/O devices can stretch any bus transfer. They do this by holding an active-low ready input high, and while they do, the sequencer freezes completely. Between instructions the block checks an interrupt request. If an interrupt is pending and enabled, the sequencer saves the next program counter value in a one-level context register and fetches from a fixed service address. A return instruction restores the saved address and re-enables interrupts.

Top module: `fxs_sequencer`

## Requirements
- R1: After synchronous reset the program counter equals RST_VEC (default 0x00), the accumulator and zero flag are zero, and the first bus cycle is an opcode read at RST_VEC.
- R2: An opcode byte is read from the program-counter address into the instruction register. A two-byte instruction then reads its operand-address byte from the next address. The program counter advances by one for each byte fetched.
- R3: The opcode is the upper 4 bits of the first byte. 0x1 loads the accumulator from memory at the operand address. 0x3 adds that memory byte to the accumulator, modulo 256. 0x2 writes the accumulator to the operand address. 0x4 jumps, 0x5 jumps if zero, and 0x6 returns from interrupt (one byte). Any other opcode is a one-byte no-operation.
- R4: `bus_rw` is 1 for every read transfer and 0 for a write transfer. During a write, `bus_wdata` equals the accumulator.
- R5: A bus transfer completes only on a rising edge where `bus_ready_n` is 0. While it is 1 during a transfer, the address, the read/write line, the request, the program counter and the accumulator all stay unchanged.
- R6: Opcode 0x4 loads the program counter with the operand byte. Opcode 0x5 does the same only when the zero flag is set; otherwise execution continues at the byte after the operand.
- R7: The zero flag is updated by opcodes 0x1 and 0x3 only. It is 1 exactly when the new accumulator value is zero.
- R8: When an instruction completes while `irq` is 1 and interrupts are enabled, the next program counter value is saved. The next fetch is then at IRQ_VEC (default 0xF0), and interrupts become disabled.
- R9: Opcode 0x6 resumes fetching at the saved address and re-enables interrupts. While interrupts are disabled, a held `irq` causes no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | ADDR_W | Bus address |
| bus_req | output | 1 | A bus transfer is in progress |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | DATA_W | Write data (accumulator) |
| bus_rdata | input | DATA_W | Read data from the selected device |
| bus_ready_n | input | 1 | Active-low transfer ready; high inserts wait states |
| irq | input | 1 | Level interrupt request |
| pc_q | output | ADDR_W | Program counter |
| ir_q | output | DATA_W | Instruction register |
| acc_q | output | DATA_W | Accumulator |

## Verification
The hardest situation to reach is an interrupt that arrives mid-program, with the request held high all through the service routine, while random wait states shift every boundary. The bench raises the request just after a known opcode fetch and keeps it high until the return opcode has been read. It then checks three things: the handler ran exactly once, the fetch after the return lands on the program counter value captured just before the vector, and the interrupted arithmetic still produces the right sum. Random programs mixing loads, adds, stores, no-ops and conditional skips run under random stalls. Their results are compared against an instruction-level model in the bench.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_JZERO = 4'h5;
  localparam logic [OPC_W-1:0] OPC_RETI  = 4'h6;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_EXEC,
    ST_BOUND
  } fxs_state_e;

  function automatic logic has_operand(input logic [OPC_W-1:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_ADD) ||
           (opc == OPC_JUMP) || (opc == OPC_JZERO);
  endfunction
endpackage

// File: rtl/fxs_alu.sv
module fxs_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_in,
  input  logic              add_sel,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  always_comb begin
    result = add_sel ? (acc_in + mem_in) : mem_in;
    zero   = (result == '0);
  end
endmodule

// File: rtl/fxs_irq_ctx.sv
module fxs_irq_ctx #(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RST_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic              leave,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              enabled,
  output logic [ADDR_W-1:0] ret_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enabled <= 1'b1;
      ret_pc  <= RST_VEC;
    end else if (enter) begin
      enabled <= 1'b0;
      ret_pc  <= pc_in;
    end else if (leave) begin
      enabled <= 1'b1;
    end
  end
endmodule

// File: rtl/fxs_ctrl.sv
module fxs_ctrl
  import fxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             ready_n,
  input  logic             zero,
  input  logic             irq_take,
  output fxs_state_e       state,
  output logic             bus_req,
  output logic             bus_rw,
  output logic             ld_ir,
  output logic             ld_mar,
  output logic             inc_pc,
  output logic             ld_acc,
  output logic             add_sel,
  output logic             jump,
  output logic             irq_enter,
  output logic             ret_do
);
  fxs_state_e nxt;
  logic done;

  assign done = !ready_n;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt       = state;
    bus_req   = 1'b0;
    bus_rw    = 1'b1;
    ld_ir     = 1'b0;
    ld_mar    = 1'b0;
    inc_pc    = 1'b0;
    ld_acc    = 1'b0;
    add_sel   = 1'b0;
    jump      = 1'b0;
    irq_enter = 1'b0;
    ret_do    = 1'b0;
    unique case (state)
      ST_FETCH: begin
        bus_req = 1'b1;
        if (done) begin
          ld_ir  = 1'b1;
          inc_pc = 1'b1;
          nxt    = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (has_operand(opc)) begin
          nxt = ST_OPND;
        end else begin
          ret_do = (opc == OPC_RETI);
          nxt    = ST_BOUND;
        end
      end
      ST_OPND: begin
        bus_req = 1'b1;
        if (done) begin
          ld_mar = 1'b1;
          inc_pc = 1'b1;
          nxt    = ST_EXEC;
        end
      end
      ST_EXEC: begin
        nxt = ST_BOUND;
        if (opc == OPC_LOAD || opc == OPC_ADD) begin
          bus_req = 1'b1;
          add_sel = (opc == OPC_ADD);
          ld_acc  = done;
          if (!done) nxt = ST_EXEC;
        end else if (opc == OPC_STORE) begin
          bus_req = 1'b1;
          bus_rw  = 1'b0;
          if (!done) nxt = ST_EXEC;
        end else if (opc == OPC_JUMP) begin
          jump = 1'b1;
        end else if (opc == OPC_JZERO) begin
          jump = zero;
        end
      end
      ST_BOUND: begin
        irq_enter = irq_take;
        nxt       = ST_FETCH;
      end
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/fxs_sequencer.sv
module fxs_sequencer
  import fxs_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] RST_VEC = 8'h00,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_req,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] acc_q
);
  localparam int PAD_W = ADDR_W - DATA_W;

  fxs_state_e        state;
  logic              ld_ir, ld_mar, inc_pc, ld_acc, add_sel, jump;
  logic              irq_enter, ret_do, irq_en, irq_take, fetch_ph;
  logic              zf_q, alu_zero;
  logic [DATA_W-1:0] alu_res;
  logic [ADDR_W-1:0] mar_q, ret_pc, rdata_addr;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_addr = {{PAD_W{1'b0}}, bus_rdata};
    end else begin : g_trunc
      assign rdata_addr = bus_rdata[ADDR_W-1:0];
    end
  endgenerate

  assign irq_take = irq && irq_en;
  assign fetch_ph = (state == ST_FETCH) || (state == ST_OPND);

  fxs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opc(ir_q[DATA_W-1 -: OPC_W]), .ready_n(bus_ready_n),
    .zero(zf_q), .irq_take(irq_take), .state(state), .bus_req(bus_req),
    .bus_rw(bus_rw), .ld_ir(ld_ir), .ld_mar(ld_mar), .inc_pc(inc_pc),
    .ld_acc(ld_acc), .add_sel(add_sel), .jump(jump), .irq_enter(irq_enter),
    .ret_do(ret_do)
  );

  fxs_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_in(acc_q), .mem_in(bus_rdata), .add_sel(add_sel),
    .result(alu_res), .zero(alu_zero)
  );

  fxs_irq_ctx #(.ADDR_W(ADDR_W), .RST_VEC(RST_VEC)) u_irq (
    .clk(clk), .rst(rst), .enter(irq_enter), .leave(ret_do), .pc_in(pc_q),
    .enabled(irq_en), .ret_pc(ret_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RST_VEC;
      ir_q  <= '0;
      mar_q <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
    end else begin
      if (irq_enter)   pc_q <= IRQ_VEC;
      else if (ret_do) pc_q <= ret_pc;
      else if (jump)   pc_q <= mar_q;
      else if (inc_pc) pc_q <= pc_q + 1'b1;
      if (ld_ir)  ir_q  <= bus_rdata;
      if (ld_mar) mar_q <= rdata_addr;
      if (ld_acc) begin
        acc_q <= alu_res;
        zf_q  <= alu_zero;
      end
    end
  end

  assign bus_addr  = fetch_ph ? pc_q : mar_q;
  assign bus_wdata = acc_q;
endmodule

// File: rtl/fxs_sequencer_chk.sv
module fxs_sequencer_chk #(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] RST_VEC = 8'h00,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_req,
  input logic              bus_rw,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready_n,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              irq_en,
  input logic              fetch_ph
);
  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_req && bus_rw && bus_addr == RST_VEC && pc_q == RST_VEC)); // R1

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_ph && bus_req && !bus_ready_n) |=> (pc_q == $past(pc_q) + 1'b1)); // R2

  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rw) |-> (bus_wdata == acc_q)); // R4

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ready_n) |=> (bus_req && $stable(bus_addr) && $stable(bus_rw) &&
                                  $stable(pc_q) && $stable(acc_q))); // R5

  AST_ACC_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc_q) |-> $past(bus_req && bus_rw && !bus_ready_n && !fetch_ph)); // R3

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_en) |-> (pc_q == IRQ_VEC)); // R8
endmodule

bind fxs_sequencer fxs_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_req(bus_req), .bus_rw(bus_rw),
  .bus_wdata(bus_wdata), .bus_ready_n(bus_ready_n), .pc_q(pc_q), .acc_q(acc_q),
  .irq_en(irq_en), .fetch_ph(fetch_ph)
);

// File: tb/fxs_sequencer_bench.sv
module fxs_sequencer_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] VEC = 8'hF0;
  localparam int NINS = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr, pc_q;
  logic bus_req, bus_rw;
  logic [DW-1:0] bus_wdata, bus_rdata, ir_q, acc_q;
  logic bus_ready_n = 1'b0;
  logic irq = 1'b0;

  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  logic [7:0] log_a [0:7];
  int log_n, end_hits, vec_hits, cycles, checks, failures;
  logic [7:0] end_addr, last_pc, ret_exp, after_ret;
  bit ret_arm, ret_seen, stall_force, wait_rand, wd_hit;

  always #10 clk = ~clk;

  fxs_sequencer u_fxs_sequencer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_req(bus_req), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready_n(bus_ready_n),
    .irq(irq), .pc_q(pc_q), .ir_q(ir_q), .acc_q(acc_q)
  );

  assign bus_rdata = mem[bus_addr];

  always @(negedge clk) begin
    if (stall_force) bus_ready_n = 1'b1;
    else bus_ready_n = wait_rand && ($urandom_range(0, 2) == 0);
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst) begin
      if (pc_q == VEC && last_pc != VEC) ret_exp = last_pc;
      last_pc = pc_q;
      if (bus_req && !bus_ready_n) begin
        if (!bus_rw) mem[bus_addr] = bus_wdata;
        else begin
          if (log_n < 8) log_a[log_n] = bus_addr;
          log_n = log_n + 1;
          if (bus_addr == end_addr) end_hits = end_hits + 1;
          if (bus_addr == VEC) vec_hits = vec_hits + 1;
          if (ret_arm) begin
            after_ret = bus_addr;
            ret_arm = 1'b0;
            ret_seen = 1'b1;
          end
          if (bus_addr == 8'hF8) ret_arm = 1'b1;
        end
      end
    end
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    log_n = 0; end_hits = 0; vec_hits = 0;
    ret_arm = 1'b0; ret_seen = 1'b0; last_pc = 8'h00;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (end_hits < 2 && n < 20000) begin
      @(posedge clk);
      n++;
    end
    chk(end_hits >= 2, req, end_hits, 2);
    @(negedge clk);
  endtask

  task automatic run_model(output logic [7:0] acc);
    logic [7:0] pc, op, a;
    bit z;
    pc = 8'h00; acc = 8'h00; z = 1'b0;
    for (int s = 0; s < 200; s++) begin
      op = ref_mem[pc] >> 4;
      a  = ref_mem[8'(pc + 1)];
      if (op == 8'h1) begin acc = ref_mem[a]; z = (acc == 0); pc = pc + 2; end
      else if (op == 8'h3) begin acc = acc + ref_mem[a]; z = (acc == 0); pc = pc + 2; end
      else if (op == 8'h2) begin ref_mem[a] = acc; pc = pc + 2; end
      else if (op == 8'h4) begin if (a == pc) break; pc = a; end
      else if (op == 8'h5) pc = z ? a : pc + 2;
      else pc = pc + 1;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic gen_prog();
    int r, t;
    clear_mem();
    for (int i = 0; i < NINS; i++) begin
      r = $urandom_range(0, 9);
      t = (i + 2 <= NINS) ? 2 * (i + 2) : 2 * NINS;
      if (r <= 2)      begin mem[2*i] = 8'h10; mem[2*i+1] = 8'h80 + 8'($urandom_range(0, 15)); end
      else if (r <= 4) begin mem[2*i] = 8'h30; mem[2*i+1] = 8'h80 + 8'($urandom_range(0, 15)); end
      else if (r <= 6) begin mem[2*i] = 8'h20; mem[2*i+1] = 8'h80 + 8'($urandom_range(0, 15)); end
      else if (r <= 8) begin mem[2*i] = 8'h50; mem[2*i+1] = 8'(t); end
      else             begin mem[2*i] = 8'h00; mem[2*i+1] = 8'h00; end
    end
    end_addr = 8'(2 * NINS);
    mem[end_addr] = 8'h40;
    mem[end_addr + 1] = end_addr;
    for (int k = 0; k < 16; k++)
      mem[8'h80 + k] = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom());
    mem[8'h8F] = 8'hFF;
    mem[8'h8E] = 8'h01;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
  endtask

  task automatic load_irq_prog();
    clear_mem();
    mem[8'h00] = 8'h10; mem[8'h01] = 8'h80;
    mem[8'h02] = 8'h30; mem[8'h03] = 8'h81;
    mem[8'h04] = 8'h30; mem[8'h05] = 8'h81;
    mem[8'h06] = 8'h30; mem[8'h07] = 8'h81;
    mem[8'h08] = 8'h20; mem[8'h09] = 8'h84;
    mem[8'h0A] = 8'h40; mem[8'h0B] = 8'h0A;
    mem[8'hF0] = 8'h20; mem[8'hF1] = 8'h85;
    mem[8'hF2] = 8'h10; mem[8'hF3] = 8'h82;
    mem[8'hF4] = 8'h20; mem[8'hF5] = 8'h83;
    mem[8'hF6] = 8'h10; mem[8'hF7] = 8'h85;
    mem[8'hF8] = 8'h60;
    mem[8'h80] = 8'h01; mem[8'h81] = 8'h02; mem[8'h82] = 8'h55;
    end_addr = 8'h0A;
  endtask

  initial begin
    logic [7:0] exp_acc, s_addr, s_pc, s_acc;
    int bad, n;
    checks = 0; failures = 0; cycles = 0; wd_hit = 1'b0;
    stall_force = 1'b0; wait_rand = 1'b0;
    void'($urandom(32'd20240611));

    // R1 reset state and first fetch
    load_irq_prog();
    do_reset();
    #1;
    chk(pc_q == 8'h00 && acc_q == 8'h00, "R1", {pc_q, acc_q}, 0);
    chk(bus_req && bus_rw && bus_addr == 8'h00, "R1 R4", {bus_req, bus_rw, bus_addr}, {2'b11, 8'h00});

    // R2 R3 directed program without interrupt, no wait states
    wait_end("R2 completion");
    chk(log_a[0] == 8'h00 && log_a[1] == 8'h01, "R2", {log_a[0], log_a[1]}, 16'h0001);
    chk(log_a[2] == 8'h80 && log_a[3] == 8'h02, "R2 R3", {log_a[2], log_a[3]}, 16'h8002);
    chk(mem[8'h84] == 8'h07, "R3 store of sum", mem[8'h84], 8'h07);
    chk(acc_q == 8'h07 && ir_q == 8'h40, "R3 R6", {acc_q, ir_q}, 16'h0740);

    // R5 forced wait state holds everything
    wait_rand = 1'b1;
    load_irq_prog();
    do_reset();
    repeat (4) @(negedge clk);
    @(posedge clk); #1 stall_force = 1'b1;
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!bus_req && n < 10);
    s_addr = bus_addr; s_pc = pc_q; s_acc = acc_q;
    repeat (5) @(negedge clk);
    #1;
    chk(bus_req && bus_addr == s_addr && pc_q == s_pc && acc_q == s_acc, "R5",
        {bus_addr, pc_q, acc_q}, {s_addr, s_pc, s_acc});
    stall_force = 1'b0;
    wait_end("R5 resume");
    chk(mem[8'h84] == 8'h07, "R5 result after stall", mem[8'h84], 8'h07);

    // R8 R9 interrupt with held request and random waits
    load_irq_prog();
    do_reset();
    n = 0;
    while (!(log_n >= 4) && n < 1000) begin @(negedge clk); n++; end
    irq = 1'b1;
    n = 0;
    while (!ret_arm && !ret_seen && n < 5000) begin @(negedge clk); n++; end
    irq = 1'b0;
    wait_end("R8 completion");
    chk(vec_hits == 1, "R9 no nesting", vec_hits, 1);
    chk(ret_seen && after_ret == ret_exp, "R9 return address", after_ret, ret_exp);
    chk(ret_exp == 8'h04 || ret_exp == 8'h06 || ret_exp == 8'h08 || ret_exp == 8'h0A,
        "R8 saved boundary", ret_exp, 8'h04);
    chk(mem[8'h83] == 8'h55, "R8 handler ran", mem[8'h83], 8'h55);
    chk(mem[8'h84] == 8'h07, "R9 program resumed", mem[8'h84], 8'h07);

    // R3 R6 R7 random programs with random wait states
    for (int p = 0; p < 8; p++) begin
      gen_prog();
      run_model(exp_acc);
      do_reset();
      wait_end("R6 random completion");
      chk(acc_q == exp_acc, "R3 R7 random acc", acc_q, exp_acc);
      bad = 0;
      for (int k = 8'h80; k < 8'h90; k++) if (mem[k] != ref_mem[k]) bad++;
      chk(bad == 0, "R6 R7 random memory", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule